// File: doc/BRIEF.md
# Cartridge Program-Bank Mapper

This block sits between an 8-bit CPU bus and the storage of a game cartridge. It holds four small configuration registers that the CPU loads by writing anywhere in a 4 KB configuration window. From those registers it assembles an 8-bit number for a 32 KB program-ROM bank. The low three bits of the fourth register pick one of four rules that merge fields of the other three registers into that number. A CPU read in the upper 32 KB of the address space is turned into a program-ROM address built from the bank number and the offset inside the window. The program-ROM size is a power of two, so addresses past its end wrap around.

The block also decodes an 8 KB work-RAM window on the CPU side and an 8 KB character-memory window on the video side. The character write enable exists only in builds where that memory is RAM. The storage arrays, the nametable arrangement and any state snapshot live outside this block.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the configuration registers at index 0, 1, 2 and 3 hold 3, 0, 0 and 7. In mode 7 this selects program bank 3, so a read at CPU 0x8000 gives ROM address 0x18000.
- R2: A CPU write whose address lies in 0x5000–0x5FFF loads `cpu_wdata` into register `cpu_addr[9:8]`. All other address bits are ignored. CPU writes anywhere else leave every register unchanged.
- R3: When the mode (register 3 bits 2:0) is 0 or 2, bank[7:4] = reg2[3:0], bank[3:2] = reg0[3:2], bank[1] = reg1[1] and bank[0] = 0.
- R4: When the mode is 1 or 3, bank[7:4] = reg2[3:0], bank[3:2] = reg0[3:2] and bank[1:0] = 0.
- R5: When the mode is 4 or 6, bank[7:4] = reg2[3:0], bank[3:1] = reg0[3:1] and bank[0] = reg1[1].
- R6: When the mode is 5 or 7, bank[7:4] = reg2[3:0] and bank[3:0] = reg0[3:0]. Register bits not named in R3–R6 have no effect on the bank.
- R7: `prg_rom_addr` equals (bank × 32768 + `cpu_addr[14:0]`) modulo 2^PRG_AW.
- R8: `prg_rom_cs` is high exactly when `cpu_rd` is high and `cpu_addr` is 0x8000 or above.
- R9: `wram_cs` is high when `cpu_rd` or `cpu_wr` is high with `cpu_addr` in 0x6000–0x7FFF. `wram_we` is high for a write in that window. `wram_addr` equals `cpu_addr[12:0]`.
- R10: `chr_cs` is high when `ppu_addr` is below 0x2000, and `chr_addr` equals `ppu_addr[12:0]`. `chr_we` equals `ppu_wr` in that window when CHR_IS_RAM is 1, and is always 0 when CHR_IS_RAM is 0.
- R11: A register write changes the bank from the clock edge that ends the write cycle. Within a cycle, `prg_rom_addr` follows `cpu_addr` without a register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | DW | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Video-side address |
| ppu_wr | input | 1 | Video-side write strobe |
| prg_rom_addr | output | PRG_AW | Translated program-ROM byte address |
| prg_rom_cs | output | 1 | Program-ROM select |
| wram_addr | output | 13 | Work-RAM byte address |
| wram_cs | output | 1 | Work-RAM select |
| wram_we | output | 1 | Work-RAM write enable |
| chr_addr | output | 13 | Character-memory byte address |
| chr_cs | output | 1 | Character-memory select |
| chr_we | output | 1 | Character-memory write enable |

## Verification
The CPU side and the video side are decoded independently, so a CPU write and a video write can land in the same cycle. The bench drives a work-RAM write together with a character write, and a configuration write together with a character write. In each case it checks that both enables are high in that cycle, that their addresses are intact, and that the bank seen on the next ROM read reflects the configuration write. The same stimulus goes to a ROM-character build, where the character enable must stay low while the CPU-side results match.

// File: rtl/prg_mapper_pkg.sv
package prg_mapper_pkg;

   localparam int CPU_AW    = 16;
   localparam int PPU_AW    = 14;
   localparam int NUM_CFG   = 4;
   localparam int CFG_IDX_W = $clog2(NUM_CFG);
   localparam int BANK_W    = 8;
   localparam int WIN_OFS_W = 15;
   localparam int WRAM_AW   = 13;
   localparam int CHR_AW    = 13;
   localparam int FULL_W    = BANK_W + WIN_OFS_W;

   localparam logic [3:0] CFG_PAGE  = 4'h5;
   localparam logic [2:0] WRAM_PAGE = 3'b011;

   typedef enum logic [1:0] {
      MERGE_R1_MID = 2'b00,
      MERGE_QUAD   = 2'b01,
      MERGE_R1_LSB = 2'b10,
      MERGE_FULL   = 2'b11
   } merge_rule_e;

   function automatic logic [7:0] cfg_reset_value(input int idx);
      case (idx)
         0:       return 8'd3;
         3:       return 8'd7;
         default: return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/prg_cfg_regs.sv
module prg_cfg_regs
   import prg_mapper_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [CFG_IDX_W-1:0]          wr_idx,
   input  logic [DW-1:0]                 wr_data,
   output logic [NUM_CFG-1:0][DW-1:0]    regs_q
);

   for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_reg
      localparam logic [7:0] RST8 = cfg_reset_value(gi);
      localparam logic [DW-1:0] RSTV = DW'(RST8);
      logic hit;
      assign hit = wr_en && (wr_idx == CFG_IDX_W'(gi));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[gi] <= RSTV;
         end else if (hit) begin
            regs_q[gi] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/prg_bank_merge.sv
module prg_bank_merge
   import prg_mapper_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [NUM_CFG-1:0][DW-1:0] regs,
   output logic [BANK_W-1:0]          bank
);

   logic [3:0]  base_nib;
   logic        r1_sel;
   logic [3:0]  hi_nib;
   logic [2:0]  mode;
   merge_rule_e rule;
   logic [3:0]  lo_nib;

   assign base_nib = regs[0][3:0];
   assign r1_sel   = regs[1][1];
   assign hi_nib   = regs[2][3:0];
   assign mode     = regs[3][2:0];
   assign rule     = merge_rule_e'({mode[2], mode[0]});

   always_comb begin
      case (rule)
         MERGE_R1_MID: lo_nib = {base_nib[3:2], r1_sel, 1'b0};
         MERGE_QUAD:   lo_nib = {base_nib[3:2], 2'b00};
         MERGE_R1_LSB: lo_nib = {base_nib[3:1], r1_sel};
         default:      lo_nib = base_nib;
      endcase
   end

   assign bank = {hi_nib, lo_nib};

   logic unused_cfg_bits;
   if (DW > 4) begin : g_unused_wide
      assign unused_cfg_bits = ^{regs[0][DW-1:4], regs[1][DW-1:4], regs[1][3:2],
                                 regs[1][0], regs[2][DW-1:4], regs[3][DW-1:3], mode[1]};
   end else begin : g_unused_narrow
      assign unused_cfg_bits = ^{regs[1][3:2], regs[1][0], regs[3][DW-1:3], mode[1]};
   end

endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
   import prg_mapper_pkg::*;
#(
   parameter bit CHR_IS_RAM = 1'b1
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [PPU_AW-1:0] ppu_addr,
   input  logic              ppu_wr,
   output logic              cfg_wr,
   output logic              prg_cs,
   output logic              wram_cs,
   output logic              wram_we,
   output logic              chr_cs,
   output logic              chr_we
);

   logic in_cfg, in_wram, in_prg, in_chr;

   assign in_cfg  = cpu_addr[CPU_AW-1 -: 4] == CFG_PAGE;
   assign in_wram = cpu_addr[CPU_AW-1 -: 3] == WRAM_PAGE;
   assign in_prg  = cpu_addr[CPU_AW-1];
   assign in_chr  = ppu_addr[PPU_AW-1 -: 1] == 1'b0;

   assign cfg_wr  = cpu_wr && in_cfg;
   assign prg_cs  = cpu_rd && in_prg;
   assign wram_cs = (cpu_rd || cpu_wr) && in_wram;
   assign wram_we = cpu_wr && in_wram;
   assign chr_cs  = in_chr;

   if (CHR_IS_RAM) begin : g_chr_ram
      assign chr_we = ppu_wr && in_chr;
   end else begin : g_chr_rom
      logic unused_ppu_wr;
      assign unused_ppu_wr = ppu_wr;
      assign chr_we = 1'b0;
   end

   logic unused_ppu_hi;
   assign unused_ppu_hi = ppu_addr[PPU_AW-2];

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import prg_mapper_pkg::*;
#(
   parameter int PRG_AW     = 17,
   parameter int DW         = 8,
   parameter bit CHR_IS_RAM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [DW-1:0]     cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [13:0]       ppu_addr,
   input  logic              ppu_wr,
   output logic [PRG_AW-1:0] prg_rom_addr,
   output logic              prg_rom_cs,
   output logic [12:0]       wram_addr,
   output logic              wram_cs,
   output logic              wram_we,
   output logic [12:0]       chr_addr,
   output logic              chr_cs,
   output logic              chr_we
);

   if (PRG_AW < WIN_OFS_W || PRG_AW > FULL_W) begin : g_bad_prg_aw
      $error("prg_bank_mapper: PRG_AW must lie between 15 and 23");
   end
   if (DW < 4) begin : g_bad_dw
      $error("prg_bank_mapper: DW must be at least 4");
   end

   logic                       cfg_wr;
   logic [NUM_CFG-1:0][DW-1:0] cfg_q;
   logic [BANK_W-1:0]          prg_bank;
   logic [FULL_W-1:0]          flat_addr;

   prg_window_decode #(
      .CHR_IS_RAM(CHR_IS_RAM)
   ) u_decode (
      .cpu_addr (cpu_addr),
      .cpu_rd   (cpu_rd),
      .cpu_wr   (cpu_wr),
      .ppu_addr (ppu_addr),
      .ppu_wr   (ppu_wr),
      .cfg_wr   (cfg_wr),
      .prg_cs   (prg_rom_cs),
      .wram_cs  (wram_cs),
      .wram_we  (wram_we),
      .chr_cs   (chr_cs),
      .chr_we   (chr_we)
   );

   prg_cfg_regs #(
      .DW(DW)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_idx  (cpu_addr[9:8]),
      .wr_data (cpu_wdata),
      .regs_q  (cfg_q)
   );

   prg_bank_merge #(
      .DW(DW)
   ) u_merge (
      .regs (cfg_q),
      .bank (prg_bank)
   );

   assign flat_addr = {prg_bank, cpu_addr[WIN_OFS_W-1:0]};

   if (PRG_AW == FULL_W) begin : g_full_rom
      assign prg_rom_addr = flat_addr;
   end else begin : g_wrapped_rom
      logic unused_bank_hi;
      assign prg_rom_addr   = flat_addr[PRG_AW-1:0];
      assign unused_bank_hi = ^flat_addr[FULL_W-1:PRG_AW];
   end

   assign wram_addr = cpu_addr[WRAM_AW-1:0];
   assign chr_addr  = ppu_addr[CHR_AW-1:0];

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
   parameter int PRG_AW     = 17,
   parameter bit CHR_IS_RAM = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic [13:0]       ppu_addr,
   input logic              ppu_wr,
   input logic [PRG_AW-1:0] prg_rom_addr,
   input logic              prg_rom_cs,
   input logic              wram_cs,
   input logic              wram_we,
   input logic              chr_we,
   input logic [7:0]        bank
);

   // R8
   prg_cs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_rom_cs |-> (cpu_rd && cpu_addr >= 16'h8000));

   // R8
   prg_cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(prg_rom_cs && wram_cs));

   // R9
   wram_we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wram_we |-> (cpu_wr && wram_cs && cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF));

   // R7
   prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prg_rom_cs |-> (prg_rom_addr[14:0] == cpu_addr[14:0]));

   // R2
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cpu_wr && cpu_addr[15:12] == 4'h5)) |=> $stable(bank));

   // R10
   chr_we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_we |-> (ppu_wr && ppu_addr < 14'h2000));

   if (!CHR_IS_RAM) begin : g_rom_chk
      // R10
      chr_rom_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ppu_wr |-> !chr_we);
   end

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
   .PRG_AW     (PRG_AW),
   .CHR_IS_RAM (CHR_IS_RAM)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_addr     (cpu_addr),
   .cpu_rd       (cpu_rd),
   .cpu_wr       (cpu_wr),
   .ppu_addr     (ppu_addr),
   .ppu_wr       (ppu_wr),
   .prg_rom_addr (prg_rom_addr),
   .prg_rom_cs   (prg_rom_cs),
   .wram_cs      (wram_cs),
   .wram_we      (wram_we),
   .chr_we       (chr_we),
   .bank         (prg_bank)
);

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;

   localparam int AW_BIG   = 23;
   localparam int AW_SMALL = 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [13:0] ppu_addr = '0;
   logic        ppu_wr = 1'b0;

   logic [AW_BIG-1:0]   a_rom_addr;
   logic [AW_SMALL-1:0] b_rom_addr;
   logic        a_rom_cs, a_wram_cs, a_wram_we, a_chr_cs, a_chr_we;
   logic        b_rom_cs, b_wram_cs, b_wram_we, b_chr_cs, b_chr_we;
   logic [12:0] a_wram_addr, a_chr_addr, b_wram_addr, b_chr_addr;

   always #4 clk = ~clk;

   prg_bank_mapper #(.PRG_AW(AW_BIG), .DW(8), .CHR_IS_RAM(1'b1)) i_prg_bank_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .prg_rom_addr(a_rom_addr), .prg_rom_cs(a_rom_cs), .wram_addr(a_wram_addr),
      .wram_cs(a_wram_cs), .wram_we(a_wram_we), .chr_addr(a_chr_addr),
      .chr_cs(a_chr_cs), .chr_we(a_chr_we));

   prg_bank_mapper #(.PRG_AW(AW_SMALL), .DW(8), .CHR_IS_RAM(1'b0)) i_prg_bank_mapper_rom (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
      .prg_rom_addr(b_rom_addr), .prg_rom_cs(b_rom_cs), .wram_addr(b_wram_addr),
      .wram_cs(b_wram_cs), .wram_we(b_wram_we), .chr_addr(b_chr_addr),
      .chr_cs(b_chr_cs), .chr_we(b_chr_we));

   int checks = 0;
   int errors = 0;
   int shadow [4] = '{3, 0, 0, 7};
   bit done = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_bank();
      int m, hi;
      m  = shadow[3] % 8;
      hi = (shadow[2] % 16) * 16;
      if (m == 0 || m == 2) return hi + (shadow[0] % 16) / 4 * 4 + (shadow[1] / 2 % 2) * 2;
      if (m == 1 || m == 3) return hi + (shadow[0] % 16) / 4 * 4;
      if (m == 4 || m == 6) return hi + (shadow[0] % 16) / 2 * 2 + (shadow[1] / 2 % 2);
      return hi + shadow[0] % 16;
   endfunction

   function automatic string mode_req();
      int m;
      m = shadow[3] % 8;
      if (m == 0 || m == 2) return "R3";
      if (m == 1 || m == 3) return "R4";
      if (m == 4 || m == 6) return "R5";
      return "R6";
   endfunction

   task automatic cfg_write(input int idx, input int data, input int junk);
      @(negedge clk);
      cpu_addr  = 16'(32'h5000 + idx * 256 + (junk % 4) * 1024 + (junk * 37) % 256);
      cpu_wdata = 8'(data);
      cpu_rd    = 1'b0;
      cpu_wr    = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
      shadow[idx] = data % 256;
   endtask

   task automatic rom_check(input string req, input int off);
      longint exp;
      @(negedge clk);
      cpu_wr   = 1'b0;
      cpu_addr = 16'(32'h8000 + off);
      cpu_rd   = 1'b1;
      #1;
      exp = longint'(exp_bank()) * 32768 + off;
      chk(req, a_rom_addr, exp);
      chk("R7", b_rom_addr, exp % 131072);
   endtask

   task automatic bus_check(input string req, input int addr, input bit rd, input bit wr,
                            input bit e_rom, input bit e_wcs, input bit e_wwe);
      @(negedge clk);
      cpu_addr = 16'(addr);
      cpu_rd   = rd;
      cpu_wr   = wr;
      #1;
      chk(req, a_rom_cs, e_rom);
      chk(req, b_rom_cs, e_rom);
      chk(req, a_wram_cs, e_wcs);
      chk(req, a_wram_we, e_wwe);
      chk(req, a_wram_addr, addr % 8192);
      @(negedge clk);
      cpu_wr = 1'b0;
      cpu_rd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int iter;
      int old_bank;
      iter = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values select bank 3 in mode 7
      rom_check("R1", 0);
      chk("R1", a_rom_addr, 32'h18000);
      chk("R8", a_rom_cs, 1);

      // R2: writes outside the config window leave the bank alone
      foreach (shadow[i]) shadow[i] = shadow[i];
      begin
         int outside [5] = '{16'h4FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hFFFF};
         foreach (outside[k]) begin
            @(negedge clk);
            cpu_addr  = 16'(outside[k]);
            cpu_wdata = 8'hAA;
            cpu_rd    = 1'b0;
            cpu_wr    = 1'b1;
            @(negedge clk);
            cpu_wr = 1'b0;
            rom_check("R2", 32'h1234 + k);
         end
      end

      // R11: bank changes only after the write edge
      cfg_write(3, 8'hF5, 0);
      cfg_write(0, 8'h01, 1);
      old_bank = exp_bank();
      @(negedge clk);
      cpu_addr  = 16'h5000;
      cpu_wdata = 8'h0C;
      cpu_wr    = 1'b1;
      #1;
      chk("R11", a_rom_addr, longint'(old_bank) * 32768 + 32'h5000);
      @(negedge clk);
      cpu_wr    = 1'b0;
      shadow[0] = 8'h0C;
      #1;
      chk("R11", a_rom_addr, longint'(exp_bank()) * 32768 + 32'h5000);
      chk("R11", old_bank == exp_bank(), 0);

      // R3-R6: sweep of mode and all relevant register fields
      for (int m = 0; m < 8; m++) begin
         cfg_write(3, 8'hA8 + m, m);
         for (int r2 = 0; r2 < 16; r2++) begin
            cfg_write(2, ((15 - r2) * 16) + r2, r2);
            for (int r1 = 0; r1 < 4; r1++) begin
               cfg_write(1, 8'hF0 + r1 + (r2 % 4) * 4, r1 + m);
               for (int r0 = 0; r0 < 16; r0++) begin
                  cfg_write(0, ((r0 + m) % 16) * 16 + r0, r0 + r1);
                  rom_check(mode_req(), (iter * 4951 + 77) % 32768);
                  iter++;
               end
            end
         end
      end

      // R8 / R9: CPU window decode
      bus_check("R8", 32'h8000, 1, 0, 1, 0, 0);
      bus_check("R8", 32'hFFFF, 1, 0, 1, 0, 0);
      bus_check("R8", 32'h8000, 0, 1, 0, 0, 0);
      bus_check("R9", 32'h7FFF, 1, 0, 0, 1, 0);
      bus_check("R9", 32'h6000, 0, 1, 0, 1, 1);
      bus_check("R9", 32'h6ABC, 0, 1, 0, 1, 1);
      bus_check("R9", 32'h5FFF, 1, 0, 0, 0, 0);
      bus_check("R9", 32'h8000 - 1, 0, 0, 0, 0, 0);

      // R10: video window sweep for both builds
      for (int p = 0; p < 16384; p += 509) begin
         for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            ppu_addr = 14'(p);
            ppu_wr   = w[0];
            #1;
            chk("R10", a_chr_cs, p < 8192);
            chk("R10", a_chr_addr, p % 8192);
            chk("R10", a_chr_we, (p < 8192) && w == 1);
            chk("R10", b_chr_we, 0);
            chk("R10", b_chr_cs, p < 8192);
         end
      end
      @(negedge clk);
      ppu_wr = 1'b0;

      // Same-cycle CPU work-RAM write and video write
      @(negedge clk);
      cpu_addr = 16'h6123;
      cpu_wr   = 1'b1;
      ppu_addr = 14'h0456;
      ppu_wr   = 1'b1;
      #1;
      chk("R9", a_wram_we, 1);
      chk("R9", a_wram_addr, 32'h0123);
      chk("R10", a_chr_we, 1);
      chk("R10", a_chr_addr, 32'h0456);
      chk("R10", b_chr_we, 0);

      // Same-cycle configuration write and video write
      @(negedge clk);
      cpu_addr  = 16'h5200;
      cpu_wdata = 8'h09;
      cpu_wr    = 1'b1;
      ppu_addr  = 14'h1FFF;
      ppu_wr    = 1'b1;
      #1;
      chk("R10", a_chr_we, 1);
      @(negedge clk);
      cpu_wr    = 1'b0;
      ppu_wr    = 1'b0;
      shadow[2] = 9;
      rom_check("R2", 32'h7FFF);

      // R1: reset mid-run restores the reset bank
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      shadow = '{3, 0, 0, 7};
      rom_check("R1", 32'h0042);
      chk("R1", a_rom_addr, 32'h18042);

      @(negedge clk);
      cpu_rd = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule